// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the internal byte address of a serial memory target and the staging buffer for one page of write data. The bus front end feeds it strobes. One loads the upper address bits taken from the device-select byte. One loads the low eight bits taken from the word-address byte. One marks each data byte received during a write, and one marks each data byte handed out during a read. The address survives between transactions, so a read that sends no address continues from where the last access stopped.

Write traffic and read traffic advance the address differently. A received write byte moves only the in-page offset, which wraps inside its page. A delivered read byte moves the whole address, which wraps from the top of the array back to zero. Each received write byte is placed in a page buffer slot chosen by the in-page offset, and a per-slot valid bit marks it. When the front end signals commit, the buffer presents the page row, the valid mask and the data in one registered beat for the array write. The buffer then empties.

Top module: `wap_word_addr`

## Requirements
- R1: After reset `cur_addr` is zero, `cm_valid` is low, and a commit with no prior write reports an all-zero mask.
- R2: `dev_ld` replaces address bits [ADDR_W-1:8] with `dev_hi` and leaves bits [7:0] unchanged. `word_ld` replaces bits [7:0] with `word_lo` and leaves the upper bits unchanged. Both may act in the same cycle. The new value shows on `cur_addr` the cycle after the strobe.
- R3: Each `wr_stb` adds one to address bits [PAGE_W-1:0], modulo 2^PAGE_W. Bits above PAGE_W are unchanged, so offset 15 is followed by offset 0 of the same page.
- R4: Each `rd_stb` without `wr_stb` adds one to the full address, modulo 2^ADDR_W. The all-ones address is followed by zero.
- R5: With no strobe, `cur_addr` keeps its value for any number of cycles.
- R6: A `wr_stb` stores `wr_data` in the buffer slot given by address bits [PAGE_W-1:0] before the increment and sets that slot's valid bit. The committed page row is address bits [ADDR_W-1:PAGE_W] of the last stored byte.
- R7: A slot written more than once before a commit reports only its last byte.
- R8: `commit` drives `cm_valid` high for exactly the next cycle. In that cycle `cm_row`, `cm_mask` and `cm_data` show the buffer. Slot i is `cm_data[8*i+7:8*i]`, and a slot with a clear mask bit reads zero. The mask is empty afterwards.
- R9: A load takes priority over the increment in the same cycle, while the byte of a coincident `wr_stb` is still stored at the pre-load address. `wr_stb` wins over `rd_stb`, and the latter is ignored in that cycle.
- R10: When `commit` and `wr_stb` coincide, the committed beat excludes the new byte. That byte becomes the only valid slot of the next buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_ld | input | 1 | Load upper address bits |
| dev_hi | input | ADDR_W-8 | Upper address bits from the device-select byte |
| word_ld | input | 1 | Load low address byte |
| word_lo | input | 8 | Low address byte |
| wr_stb | input | 1 | One write data byte received |
| wr_data | input | 8 | Received write byte |
| rd_stb | input | 1 | One read data byte delivered |
| commit | input | 1 | Hand the buffered page to the array |
| cur_addr | output | ADDR_W | Current word address |
| cm_valid | output | 1 | Commit beat present |
| cm_row | output | ADDR_W-PAGE_W | Page row of the commit beat |
| cm_mask | output | 2^PAGE_W | Valid slots of the commit beat |
| cm_data | output | 8·2^PAGE_W | Slot data of the commit beat |

## Verification
The bench writes more than a page of bytes from an offset near the page end. A counter that carried into the row bits would move the row, and one that failed to wrap would leave the first slots with stale data. It reads across the all-ones address, where a counter borrowing the page wrap would stay in the last page. It also hits coincident strobes: a load over an increment, a write over a read, and a write in the same cycle as a commit. A buffer that cleared its mask after setting the new bit would lose that byte. The random phase shuffles all strobes against a reference model.

// File: rtl/wap_pkg.sv
package wap_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_PAGE,
        STEP_FULL
    } step_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } load_t;

    // write traffic outranks read traffic
    function automatic step_e pick_step(input logic wr, input logic rd);
        if (wr)
            return STEP_PAGE;
        if (rd)
            return STEP_FULL;
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/wap_addr_ctr.sv
module wap_addr_ctr
    import wap_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  step_e                    step,
    input  load_t                    load,
    input  logic [ADDR_W-BYTE_W-1:0] hi_val,
    input  logic [BYTE_W-1:0]        lo_val,
    output logic [ADDR_W-1:0]        addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_n;

    always_comb begin
        addr_n = addr_q;
        unique case (step)
            STEP_PAGE: addr_n[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + 1'b1;
            STEP_FULL: addr_n = addr_q + 1'b1;
            default:   addr_n = addr_q;
        endcase
        if (load.hi)
            addr_n[ADDR_W-1:BYTE_W] = hi_val[HI_W-1:0];
        if (load.lo)
            addr_n[BYTE_W-1:0] = lo_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else
            addr_q <= addr_n;
    end

    assign addr = addr_q;

endmodule

// File: rtl/wap_page_buf.sv
module wap_page_buf
    import wap_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int ROW_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PAGE_W-1:0]          wr_idx,
    input  logic [ROW_W-1:0]           wr_row,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       commit,
    output logic                       cm_valid,
    output logic [ROW_W-1:0]           cm_row,
    output logic [(1<<PAGE_W)-1:0]     cm_mask,
    output logic [(1<<PAGE_W)*BYTE_W-1:0] cm_data
);
    localparam int NB = 1 << PAGE_W;

    logic [NB-1:0]              mask_q;
    logic [NB-1:0]              mask_n;
    logic [ROW_W-1:0]           row_q;
    logic [NB-1:0][BYTE_W-1:0]  snap;

    for (genvar i = 0; i < NB; i++) begin : g_slot
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PAGE_W'(i))
                byte_q <= wr_data;
        end
        assign snap[i] = mask_q[i] ? byte_q : '0;
    end

    // clear first, then set: a byte arriving with commit opens the next page
    always_comb begin
        mask_n = commit ? '0 : mask_q;
        if (wr_en)
            mask_n[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            row_q    <= '0;
            cm_valid <= 1'b0;
            cm_row   <= '0;
            cm_mask  <= '0;
            cm_data  <= '0;
        end else begin
            mask_q   <= mask_n;
            cm_valid <= commit;
            if (wr_en)
                row_q <= wr_row;
            if (commit) begin
                cm_row  <= row_q;
                cm_mask <= mask_q;
                cm_data <= snap;
            end
        end
    end

endmodule

// File: rtl/wap_word_addr.sv
module wap_word_addr
    import wap_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                dev_ld,
    input  logic [ADDR_W-8-1:0]                 dev_hi,
    input  logic                                word_ld,
    input  logic [7:0]                          word_lo,
    input  logic                                wr_stb,
    input  logic [7:0]                          wr_data,
    input  logic                                rd_stb,
    input  logic                                commit,
    output logic [ADDR_W-1:0]                   cur_addr,
    output logic                                cm_valid,
    output logic [ADDR_W-PAGE_W-1:0]            cm_row,
    output logic [(1<<PAGE_W)-1:0]              cm_mask,
    output logic [(1<<PAGE_W)*8-1:0]            cm_data
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    step_e             step;
    load_t             load;
    logic [ADDR_W-1:0] addr;

    assign step    = pick_step(wr_stb, rd_stb);
    assign load.hi = dev_ld;
    assign load.lo = word_ld;

    wap_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .load   (load),
        .hi_val (dev_hi),
        .lo_val (word_lo),
        .addr   (addr)
    );

    wap_page_buf #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_stb),
        .wr_idx   (addr[PAGE_W-1:0]),
        .wr_row   (addr[ADDR_W-1:PAGE_W]),
        .wr_data  (wr_data),
        .commit   (commit),
        .cm_valid (cm_valid),
        .cm_row   (cm_row),
        .cm_mask  (cm_mask),
        .cm_data  (cm_data)
    );

    assign cur_addr = addr;

endmodule

// File: rtl/wap_word_addr_chk.sv
module wap_word_addr_chk #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          dev_ld,
    input logic [ADDR_W-8-1:0]           dev_hi,
    input logic                          word_ld,
    input logic [7:0]                    word_lo,
    input logic                          wr_stb,
    input logic [7:0]                    wr_data,
    input logic                          rd_stb,
    input logic                          commit,
    input logic [ADDR_W-1:0]             cur_addr,
    input logic                          cm_valid,
    input logic [ADDR_W-PAGE_W-1:0]      cm_row,
    input logic [(1<<PAGE_W)-1:0]        cm_mask,
    input logic [(1<<PAGE_W)*8-1:0]      cm_data
);
    logic quiet;
    assign quiet = !dev_ld && !word_ld;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && !cm_valid));

    assert_low_load_R2: assert property (@(posedge clk) disable iff (rst)
        (word_ld && !dev_ld) |=> (cur_addr[7:0] == $past(word_lo)));

    assert_page_row_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && quiet) |=> (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])));

    assert_full_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !wr_stb && quiet) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !rd_stb && quiet) |=> $stable(cur_addr));

    assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> cm_valid);

    assert_no_spurious_beat_R8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> !cm_valid);

endmodule

bind wap_word_addr wap_word_addr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/wap_word_addr_test.sv
`timescale 1ns/1ps
module wap_word_addr_test;
    localparam int ADDR_W = 9;
    localparam int PAGE_W = 4;
    localparam int NB     = 1 << PAGE_W;
    localparam int ROW_W  = ADDR_W - PAGE_W;
    localparam int DW     = NB * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_ld = 0, word_ld = 0, wr_stb = 0, rd_stb = 0, commit = 0;
    logic [ADDR_W-9:0] dev_hi = '0;
    logic [7:0] word_lo = '0, wr_data = '0;
    logic [ADDR_W-1:0] cur_addr;
    logic cm_valid;
    logic [ROW_W-1:0] cm_row;
    logic [NB-1:0] cm_mask;
    logic [DW-1:0] cm_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wap_word_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uut (
        .clk(clk), .rst(rst), .dev_ld(dev_ld), .dev_hi(dev_hi),
        .word_ld(word_ld), .word_lo(word_lo), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .commit(commit),
        .cur_addr(cur_addr), .cm_valid(cm_valid), .cm_row(cm_row),
        .cm_mask(cm_mask), .cm_data(cm_data)
    );

    // reference model state
    logic [ADDR_W-1:0] m_addr = '0;
    logic [7:0]        m_mem [NB];
    logic [NB-1:0]     m_mask = '0;
    logic [ROW_W-1:0]  m_row = '0;
    logic [ROW_W-1:0]  e_row;
    logic [NB-1:0]     e_mask;
    logic [DW-1:0]     e_data;
    logic              e_valid;

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
            input bit wr, input bit rd, input bit lh, input logic [ADDR_W-9:0] h,
            input bit ll, input logic [7:0] l);
        logic [ADDR_W-1:0] n;
        n = a;
        if (wr)      n = {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1)};
        else if (rd) n = ADDR_W'(a + 1);
        if (lh) n[ADDR_W-1:8] = h;
        if (ll) n[7:0] = l;
        return n;
    endfunction

    function automatic logic [DW-1:0] pack_buf();
        logic [DW-1:0] d;
        d = '0;
        for (int i = 0; i < NB; i++)
            if (m_mask[i]) d[i*8 +: 8] = m_mem[i];
        return d;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // one clock with the given strobes; outputs checked 1 ns after the edge
    task automatic cyc(input bit lh, input logic [ADDR_W-9:0] h, input bit ll,
            input logic [7:0] l, input bit wr, input logic [7:0] wd,
            input bit rd, input bit cm, input string req);
        logic [PAGE_W-1:0] slot;
        dev_ld = lh; dev_hi = h; word_ld = ll; word_lo = l;
        wr_stb = wr; wr_data = wd; rd_stb = rd; commit = cm;
        @(posedge clk); #1;
        dev_ld = 0; word_ld = 0; wr_stb = 0; rd_stb = 0; commit = 0;
        e_valid = cm;
        if (cm) begin
            e_row = m_row; e_mask = m_mask; e_data = pack_buf();
            m_mask = '0;
        end
        if (wr) begin
            slot = m_addr[PAGE_W-1:0];
            m_mem[slot] = wd;
            m_mask[slot] = 1'b1;
            m_row = m_addr[ADDR_W-1:PAGE_W];
        end
        m_addr = next_addr(m_addr, wr, rd, lh, h, ll, l);
        chk({req, " addr"}, DW'(cur_addr), DW'(m_addr));
        chk({req, " valid"}, DW'(cm_valid), DW'(e_valid));
        if (cm) begin
            chk({req, " row"}, DW'(cm_row), DW'(e_row));
            chk({req, " mask"}, DW'(cm_mask), DW'(e_mask));
            chk({req, " data"}, cm_data, e_data);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NB; i++) m_mem[i] = '0;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 addr", DW'(cur_addr), '0);
        chk("R1 valid", DW'(cm_valid), '0);
        rst = 0;
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R1 empty commit");
        // R2: separate and joint loads
        cyc(1, 1'b1, 0, 0, 0, 0, 0, 0, "R2 hi only");
        cyc(0, 0, 1, 8'h3E, 0, 0, 0, 0, "R2 lo only");
        // R5: idle hold
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5 hold");
        // R3/R7: 18 bytes from offset 14 wrap inside the page
        for (int k = 0; k < 18; k++)
            cyc(0, 0, 0, 0, 1, 8'(8'hA0 + k), 0, 0, "R3 page step");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R7 overwrite commit");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R8 mask cleared");
        // R6: partial page
        cyc(1, 0, 1, 8'h45, 0, 0, 0, 0, "R2 joint load");
        cyc(0, 0, 0, 0, 1, 8'h11, 0, 0, "R6 write");
        cyc(0, 0, 0, 0, 1, 8'h22, 0, 0, "R6 write");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R6 partial commit");
        // R4: read across top of array
        cyc(1, 1'b1, 1, 8'hFE, 0, 0, 0, 0, "R2 load top");
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 1, 0, "R4 full wrap");
        // R9: priorities
        cyc(0, 0, 0, 0, 1, 8'h5A, 1, 0, "R9 wr over rd");
        cyc(0, 0, 1, 8'h80, 1, 8'h6B, 0, 0, "R9 load over step");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R9 commit");
        // R10: commit coinciding with a write
        cyc(0, 0, 0, 0, 1, 8'h01, 0, 0, "R10 pre");
        cyc(0, 0, 0, 0, 1, 8'h02, 0, 1, "R10 overlap");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R10 next page");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            automatic int r = int'($urandom % 100);
            cyc(r < 6, ($urandom % 2) != 0, (r % 17) == 0, 8'($urandom),
                r >= 20 && r < 60, 8'($urandom), r >= 45 && r < 85,
                (r % 9) == 0, "R3 R4 R8 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule